// File: doc/BRIEF.md
# Bad Block Scan Sequencer

This block surveys every erase block of a 1024-block NAND array once `start` is pulsed. It does not drive the flash pins itself. It raises one read request at a time toward a host-side command sequencer. Each request carries a page address and a column address. It then waits for the single returned byte. Four marker bytes can be inspected for each block: byte 0 and the first spare-area byte (column 2048), each on the first and on the second page of the block.

A block counts as bad as soon as one inspected byte differs from FFh. The remaining markers of that block are then skipped. The verdict is written into an internal one-bit-per-block map, and a bad-block tally is kept. When the last block has been classified, a one-cycle `done` pulse is given.

At that point, `over_limit` tells whether more than the permitted number of bad blocks (20) was found. `blk0_bad` warns that block 0, which should always be usable, read as bad. Erase logic elsewhere asks whether a block may be erased through the combinational `query_blk`/`query_bad` port.

Top module: `bad_block_scanner`

## Requirements
- R1: For block b, requests run in this order: (page b·64, column 0), (page b·64, column 2048), (page b·64+1, column 0), (page b·64+1, column 2048). The block number sits in page bits 15:6 and page bits 5:1 are zero.
- R2: Only one request is outstanding. `req_valid` and its address stay steady until `rsp_valid` is seen, and `req_valid` is low for at least one cycle before the next request.
- R3: A block is bad when any inspected byte is not FFh. After the first such byte, the block's remaining markers are not requested and the scan moves on to the next block.
- R4: `query_bad` returns the map bit of `query_blk` combinationally, with 1 meaning bad.
- R5: An accepted `start` clears the map, `bad_count`, `over_limit` and `blk0_bad` before any block is classified.
- R6: The scan visits blocks 0 to 1023 in ascending order. After the last response, `done` pulses for exactly one cycle and `busy` falls.
- R7: `bad_count` equals the number of blocks classified bad and grows by at most one per cycle.
- R8: `over_limit` is 1 exactly when `bad_count` exceeds 20.
- R9: `blk0_bad` is set when block 0 is classified bad, and only then.
- R10: `start` while busy has no effect on the scan, and `rsp_valid` with no request outstanding is ignored.
- R11: After reset, `busy`, `req_valid`, `done`, `bad_count`, `over_limit`, `blk0_bad` and every map bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (honoured only when idle) |
| req_valid | output | 1 | A read request is outstanding |
| req_page | output | 16 | Page address of the request |
| req_col | output | 12 | Column address of the request |
| rsp_valid | input | 1 | Host returns the requested byte this cycle |
| rsp_data | input | 8 | Byte read from the array |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan completion |
| bad_count | output | 11 | Number of blocks classified bad |
| over_limit | output | 1 | More than 20 bad blocks found |
| blk0_bad | output | 1 | Block 0 classified bad |
| query_blk | input | 10 | Block whose map bit is requested |
| query_bad | output | 1 | Map bit of `query_blk`, 1 = bad |

## Verification
The bound checker checks the following on every cycle:
- the request handshake: address held while waiting, and a gap after each response;
- the legal page and column shapes;
- the single-cycle `done` pulse;
- the tie between `over_limit` and the tally;
- the one-per-cycle growth of the tally;
- that the block-0 warning rises only from a bad verdict on block 0.

The following can only be shown by the bench scenarios, which compare against a host model that answers from its own marker table:
- the exact request order, including the early skip after a bad byte;
- each block's final map bit;
- the limit boundary at exactly 20 and 21 bad blocks;
- clearing between scans;
- immunity to stray `start` and `rsp_valid`.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } scan_st_e;

  // Markers inspected per block: bit 1 selects the page, bit 0 the column.
  localparam int unsigned MARKERS = 4;

  function automatic int unsigned marker_page(int unsigned blk, logic [1:0] step,
                                              int unsigned shift);
    return (blk << shift) | {31'd0, step[1]};
  endfunction

  function automatic int unsigned marker_col(logic [1:0] step, int unsigned spare);
    return step[0] ? spare : 0;
  endfunction

  function automatic logic marker_is_bad(logic [7:0] b);
    return b != 8'hFF;
  endfunction

endpackage

// File: rtl/bbs_walker.sv
module bbs_walker #(
  parameter int unsigned NUM_BLOCKS = 1024,
  parameter int unsigned BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic             byte_bad,
  output logic [BLK_W-1:0] cur_blk,
  output logic [1:0]       cur_step,
  output logic             blk_done,
  output logic             last_blk
);
  localparam logic [BLK_W-1:0] LAST = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [1:0]       LAST_STEP = 2'(bbs_pkg::MARKERS - 1);

  assign blk_done = advance && (byte_bad || cur_step == LAST_STEP);
  assign last_blk = (cur_blk == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_blk  <= '0;
      cur_step <= '0;
    end else if (clear) begin
      cur_blk  <= '0;
      cur_step <= '0;
    end else if (blk_done) begin
      cur_step <= '0;
      if (!last_blk) cur_blk <= cur_blk + 1'b1;
    end else if (advance) begin
      cur_step <= cur_step + 1'b1;
    end
  end
endmodule

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
  parameter int unsigned NUM_BLOCKS = 1024,
  parameter int unsigned BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [NUM_BLOCKS-1:0] bits;

  assign rd_bit = bits[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits <= '0;
    else if (clear)  bits <= '0;
    else if (wr_en)  bits[wr_idx] <= wr_val;
  end
endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned MAX_BAD = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             blk_done,
  input  logic             blk_bad,
  input  logic             blk_is_zero,
  output logic [CNT_W-1:0] bad_count,
  output logic             over_limit,
  output logic             blk0_bad
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

  logic [CNT_W-1:0] next_count;
  assign next_count = bad_count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_count  <= '0;
      over_limit <= 1'b0;
      blk0_bad   <= 1'b0;
    end else if (clear) begin
      bad_count  <= '0;
      over_limit <= 1'b0;
      blk0_bad   <= 1'b0;
    end else if (blk_done && blk_bad) begin
      bad_count  <= next_count;
      over_limit <= (next_count > LIMIT);
      if (blk_is_zero) blk0_bad <= 1'b1;
    end
  end
endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
  parameter int unsigned NUM_BLOCKS = 1024,
  parameter int unsigned PG_SHIFT   = 6,
  parameter int unsigned PAGE_W     = 16,
  parameter int unsigned COL_W      = 12,
  parameter int unsigned SPARE_COL  = 2048,
  parameter int unsigned MAX_BAD    = 20,
  parameter int unsigned BLK_W      = $clog2(NUM_BLOCKS),
  parameter int unsigned CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  output logic [PAGE_W-1:0] req_page,
  output logic [COL_W-1:0]  req_col,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  bad_count,
  output logic              over_limit,
  output logic              blk0_bad,
  input  logic [BLK_W-1:0]  query_blk,
  output logic              query_bad
);
  import bbs_pkg::*;

  scan_st_e         state;
  logic             scan_clear;
  logic             advance;
  logic             byte_bad;
  logic             blk_done;
  logic             blk_bad;
  logic             last_blk;
  logic             scan_end;
  logic [BLK_W-1:0] cur_blk;
  logic [1:0]       cur_step;

  // Named internal events
  assign scan_clear = start && (state == ST_IDLE);
  assign advance    = (state == ST_REQ) && rsp_valid;
  assign byte_bad   = marker_is_bad(rsp_data);
  assign blk_bad    = blk_done && byte_bad;
  assign scan_end   = blk_done && last_blk;

  assign req_valid = (state == ST_REQ);
  assign busy      = (state != ST_IDLE);
  assign req_page  = PAGE_W'(marker_page(int'(cur_blk), cur_step, PG_SHIFT));
  assign req_col   = COL_W'(marker_col(cur_step, SPARE_COL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= scan_end;
      unique case (state)
        ST_IDLE: if (scan_clear) state <= ST_REQ;
        ST_REQ:  if (advance) state <= scan_end ? ST_IDLE : ST_GAP;
        ST_GAP:  state <= ST_REQ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  bbs_walker #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (scan_clear),
    .advance  (advance),
    .byte_bad (byte_bad),
    .cur_blk  (cur_blk),
    .cur_step (cur_step),
    .blk_done (blk_done),
    .last_blk (last_blk)
  );

  bbs_bitmap #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (scan_clear),
    .wr_en  (blk_done),
    .wr_idx (cur_blk),
    .wr_val (byte_bad),
    .rd_idx (query_blk),
    .rd_bit (query_bad)
  );

  bbs_tally #(.CNT_W(CNT_W), .MAX_BAD(MAX_BAD)) u_tally (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (scan_clear),
    .blk_done    (blk_done),
    .blk_bad     (byte_bad),
    .blk_is_zero (cur_blk == '0),
    .bad_count   (bad_count),
    .over_limit  (over_limit),
    .blk0_bad    (blk0_bad)
  );
endmodule

// File: rtl/bbs_scan_chk.sv
module bbs_scan_chk #(
  parameter int unsigned PAGE_W    = 16,
  parameter int unsigned COL_W     = 12,
  parameter int unsigned PG_SHIFT  = 6,
  parameter int unsigned SPARE_COL = 2048,
  parameter int unsigned MAX_BAD   = 20,
  parameter int unsigned BLK_W     = 10,
  parameter int unsigned CNT_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [PAGE_W-1:0] req_page,
  input logic [COL_W-1:0]  req_col,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  bad_count,
  input logic              over_limit,
  input logic              blk0_bad,
  input logic              blk_done,
  input logic              blk_bad,
  input logic [BLK_W-1:0]  cur_blk
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_page) && $stable(req_col));

  a_r2_gap_after_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_valid |=> !req_valid);

  a_r1_address_shape: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_page[PG_SHIFT-1:1] == '0) &&
                  (req_col == '0 || req_col == COL_W'(SPARE_COL)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bad_count == $past(bad_count)) || (bad_count == $past(bad_count) + 1'b1));

  a_r8_limit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit == (bad_count > LIMIT));

  a_r9_block0_warning: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk0_bad) |-> $past(blk_done && blk_bad && cur_blk == '0));

  a_r10_no_request_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind bad_block_scanner bbs_scan_chk #(
  .PAGE_W(PAGE_W), .COL_W(COL_W), .PG_SHIFT(PG_SHIFT), .SPARE_COL(SPARE_COL),
  .MAX_BAD(MAX_BAD), .BLK_W(BLK_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .req_page   (req_page),
  .req_col    (req_col),
  .busy       (busy),
  .done       (done),
  .bad_count  (bad_count),
  .over_limit (over_limit),
  .blk0_bad   (blk0_bad),
  .blk_done   (blk_done),
  .blk_bad    (blk_bad),
  .cur_blk    (cur_blk)
);

// File: tb/bad_block_scanner_bench.sv
module bad_block_scanner_bench;
  localparam int NB = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid;
  logic [15:0] req_page;
  logic [11:0] req_col;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'hFF;
  logic        busy, done, over_limit, blk0_bad, query_bad;
  logic [10:0] bad_count;
  logic [9:0]  query_blk = '0;

  bad_block_scanner u_bad_block_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_page(req_page), .req_col(req_col), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .done(done), .bad_count(bad_count),
    .over_limit(over_limit), .blk0_bad(blk0_bad), .query_blk(query_blk),
    .query_bad(query_bad)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [3:0] mask [NB];
  logic [7:0] badval [NB];
  int exp_blk, exp_step, seq_err;
  logic answered = 1'b0;
  logic inject = 1'b0;
  int wait_cnt = 0;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_page(int b, int s);
    return b * 64 + s / 2;
  endfunction

  function automatic int exp_col(int s);
    return (s % 2) * 2048;
  endfunction

  function automatic int exp_bad_total();
    int n = 0;
    for (int b = 0; b < NB; b++) if (mask[b] != 4'd0) n++;
    return n;
  endfunction

  // Host model: answers each request from the marker table, checks order (R1, R3)
  initial begin
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (inject) begin
        rsp_valid = 1'b1;
        rsp_data  = 8'h00;
      end else if (req_valid && !answered) begin
        if (wait_cnt == 0) begin
          int b, idx;
          logic bad_now;
          b = int'(req_page[15:6]);
          idx = int'(req_page[0]) * 2 + ((req_col == 12'd2048) ? 1 : 0);
          if (int'(req_page) != exp_page(exp_blk, exp_step) ||
              int'(req_col) != exp_col(exp_step)) seq_err++;
          bad_now = mask[b][idx];
          rsp_data = bad_now ? badval[b] : 8'hFF;
          rsp_valid = 1'b1;
          answered = 1'b1;
          wait_cnt = int'($urandom % 3);
          if (bad_now || exp_step == 3) begin
            exp_blk++;
            exp_step = 0;
          end else exp_step++;
        end else wait_cnt--;
      end
      if (!req_valid) answered = 1'b0;
    end
  end

  task automatic run_scan(string tag, bit poke_start);
    int exp_n;
    exp_blk = 0; exp_step = 0; seq_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R5 count cleared at start"}, int'(bad_count), 0);
    if (poke_start) begin
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk({tag, " R10 busy after stray start"}, int'(busy), 1);
    end
    while (!done) @(negedge clk);
    exp_n = exp_bad_total();
    chk({tag, " R1 R3 request order errors"}, seq_err, 0);
    chk({tag, " R6 all blocks visited"}, exp_blk, NB);
    chk({tag, " R6 idle at done"}, int'(busy), 0);
    chk({tag, " R7 bad count"}, int'(bad_count), exp_n);
    chk({tag, " R8 over limit"}, int'(over_limit), (exp_n > 20) ? 1 : 0);
    chk({tag, " R9 block0 warning"}, int'(blk0_bad), (mask[0] != 0) ? 1 : 0);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, int'(done), 0);
    for (int b = 0; b < NB; b++) begin
      query_blk = 10'(b);
      #1;
      chk({tag, " R4 map bit"}, int'(query_bad), (mask[b] != 0) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic fill_markers(int count, int stride);
    for (int b = 0; b < NB; b++) begin mask[b] = 4'd0; badval[b] = 8'h00; end
    for (int k = 0; k < count; k++) begin
      int b = NB - 1 - k * stride;
      mask[b] = 4'(1 + $urandom % 15);
      badval[b] = 8'($urandom % 255);
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin mask[b] = 4'd0; badval[b] = 8'h00; end
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 req_valid after reset", int'(req_valid), 0);
    chk("R11 bad_count after reset", int'(bad_count), 0);
    chk("R11 flags after reset", int'({done, over_limit, blk0_bad}), 0);
    query_blk = 10'd5; #1;
    chk("R11 map bit after reset", int'(query_bad), 0);
    @(negedge clk); rst_n = 1'b1;

    // Stray response while idle (R10)
    @(negedge clk); inject = 1'b1;
    @(negedge clk); inject = 1'b0;
    chk("R10 stray response no request", int'(req_valid), 0);
    chk("R10 stray response no busy", int'(busy), 0);
    chk("R10 stray response no count", int'(bad_count), 0);

    // Scan 1: sparse random bad blocks, directed single-marker cases (R3)
    for (int b = 0; b < NB; b++) begin
      mask[b] = ($urandom % 100 == 0) ? 4'(1 + $urandom % 15) : 4'd0;
      badval[b] = 8'($urandom % 255);
    end
    mask[0] = 4'd0;
    mask[1] = 4'b0001; badval[1] = 8'h7F;
    mask[1023] = 4'b1000; badval[1023] = 8'hFE;
    mask[512] = 4'b0100; badval[512] = 8'h00;
    run_scan("scan1", 1'b0);

    // Scan 2: exactly the limit, stray start mid-scan (R8, R10)
    fill_markers(20, 51);
    run_scan("scan2", 1'b1);

    // Scan 3: one over the limit, block 0 bad (R8, R9)
    mask[0] = 4'b0100; badval[0] = 8'h0F;
    run_scan("scan3", 1'b0);

    // Scan 4: all good, map must be cleared (R5)
    for (int b = 0; b < NB; b++) mask[b] = 4'd0;
    run_scan("scan4", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: got 0 expected 1 (scan never ended)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule